// File: doc/BRIEF.md
# Descriptor Ring Walker

This block follows a circular list of buffer descriptors kept in system memory on behalf of one direction of a network controller. A direction strap says whether the descriptors belong to the receive path or the transmit path. A three-bit slice of a format configuration word sets the descriptor layout. The walker fetches every word of the current descriptor over a read port that allows one request at a time. It then decodes the buffer address, the length and the wrap flag, and decides whether the descriptor still belongs to the hardware.

A descriptor that belongs to the hardware is offered to the consumer as a held handshake. When the consumer returns a status word, the walker writes the descriptor back over a write port. Each written word goes to the same address it was read from. The walker then moves to the next descriptor, or back to the queue base when the wrap flag is set. Walking continues without further prompting. It stops and goes idle when it meets a descriptor that software still owns. It halts on a transmit descriptor that is malformed. A kick resumes it at the current descriptor. A rewind moves it back to the queue base.

Top module: `ringWalker`

## Requirements
- R1: The word count is 2 + 2·A + 2·E. A is `cfgWord` bit 30 (wide addressing). E is bit 28 when `rxMode` is 1 and bit 29 when `rxMode` is 0 (extended layout). The extended bit of the other direction has no effect.
- R2: Descriptor words are read one at a time, in ascending order, at `curDesc + 4·i`. Each request stays asserted with a stable address until `rdReady`, and the next request waits for `rdValid`. Reads and writes never overlap.
- R3: `bufAddr[31:0]` is word 0, with bits 1:0 cleared in receive mode. `bufAddr[63:32]` is word 2 when bit 30 is set and zero otherwise. The offer is held stable until `done`.
- R4: In receive mode, bit 0 of word 0 set (owned by software) makes the walker go idle without an offer. Bit 1 of word 0 is the wrap flag. `bufLen` is word 1 bits 12:0.
- R5: In transmit mode, bit 31 of word 1 set (already used) makes the walker go idle without an offer. Bit 30 of word 1 is the wrap flag. `bufLen` is word 1 bits 13:0.
- R6: A transmit descriptor with a 64-bit buffer address of zero, or a length of zero, raises `halted`. It is neither offered nor written back.
- R7: After write-back, the next descriptor address is the aligned queue base when the wrap flag is set. Otherwise it is `curDesc` + 4 × word count.
- R8: Write-back writes exactly the words that were fetched, at the same addresses. Receive: word 0 gets bit 0 set, and word 1 takes `statusIn`. Transmit: word 0 is kept, and word 1 becomes {1, wrap, `statusIn[29:0]`}. Words 2–3 are kept when wide addressing is on. The extended pair, which carries the timestamp and its valid flag, is written as zero.
- R9: `rewind` in idle or halted loads `queueBase` with bits 1:0 cleared, so `curDesc` is always word aligned.
- R10: The format (A, E, direction) is sampled when a descriptor's fetch starts and held until that descriptor's write-back ends. A change made while a descriptor is in progress first applies to the next descriptor.
- R11: After reset `idle` is 1, `curDesc` is 0, and `rdReq`, `wrReq`, `descValid` and `halted` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxMode | input | 1 | 1: receive descriptors, 0: transmit descriptors |
| cfgWord | input | 32 | Format configuration word (bits 30, 29, 28 used) |
| queueBase | input | 32 | Ring base address |
| rewind | input | 1 | Load queue base as current descriptor (idle/halted) |
| kick | input | 1 | Start walking at current descriptor (idle/halted) |
| rdReq | output | 1 | Read request valid |
| rdAddr | output | 32 | Read word address |
| rdReady | input | 1 | Read request accepted |
| rdValid | input | 1 | Read data valid |
| rdData | input | 32 | Read data |
| wrReq | output | 1 | Write request valid |
| wrAddr | output | 32 | Write word address |
| wrData | output | 32 | Write data |
| wrReady | input | 1 | Write accepted |
| descValid | output | 1 | Descriptor offered to consumer |
| bufAddr | output | 64 | Buffer address of offered descriptor |
| bufLen | output | 14 | Buffer length of offered descriptor |
| bufWrap | output | 1 | Wrap flag of offered descriptor |
| done | input | 1 | Consumer finished with the offer |
| statusIn | input | 32 | Status returned with `done` |
| curDesc | output | 32 | Current descriptor address |
| idle | output | 1 | Stopped on a descriptor owned by software, or after reset |
| halted | output | 1 | Stopped on a malformed transmit descriptor |

## Verification
None of this block's results arrives at a fixed latency, because the bench stalls the read and write ports at an uneven rate. The offer fields are levels held from the cycle `descValid` rises until the cycle after `done`. The bench therefore polls on falling edges until `descValid` is seen and compares the fields in that same cycle. Stopping is checked the same way, once `idle` or `halted` is first seen. Write-back contents and the untouched neighbouring words are read from the bench's memory model only after the walker has stopped, when no write can still be pending.

// File: rtl/walkPkg.sv
package walkPkg;
  localparam int WORD_W     = 32;
  localparam int MAX_WORDS  = 6;
  localparam int IDX_W      = $clog2(MAX_WORDS + 1);
  localparam int LEN_W      = 14;
  localparam int RX_LEN_W   = 13;
  localparam int CFG_A64    = 30;
  localparam int CFG_EXT_TX = 29;
  localparam int CFG_EXT_RX = 28;
  localparam int RX_OWN     = 0;
  localparam int RX_WRAP    = 1;
  localparam int TX_USED    = 31;
  localparam int TX_WRAP    = 30;

  typedef struct packed {
    logic latchFmt;
    logic firstWord;
    logic nextWord;
    logic capWord;
    logic stepRing;
    logic loadBase;
  } walkStrobe_t;
endpackage

// File: rtl/walkData.sv
module walkData
  import walkPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobe_t         stb,
  input  logic                rxMode,
  input  logic [WORD_W-1:0]   cfgWord,
  input  logic [ADDR_W-1:0]   queueBase,
  input  logic [WORD_W-1:0]   rdData,
  input  logic [WORD_W-1:0]   statusIn,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [ADDR_W-1:0]   curDesc,
  output logic [WORD_W-1:0]   wrData,
  output logic                lastWord,
  output logic                stopHere,
  output logic                invalid,
  output logic [2*WORD_W-1:0] bufAddr,
  output logic [LEN_W-1:0]    bufLen,
  output logic                bufWrap
);
  logic fmtRx, fmtA64, fmtExt;
  logic [IDX_W-1:0]  wordIdx, wordCnt, extBase;
  logic [ADDR_W-1:0] ptr, baseAligned;
  logic [WORD_W-1:0] words [MAX_WORDS];
  logic [WORD_W-1:0] lo, hi;
  logic unusedBits;

  assign unusedBits  = ^{cfgWord[WORD_W-1], cfgWord[CFG_EXT_RX-1:0], cfgWord[CFG_EXT_RX-1:0], queueBase[1:0]};
  assign baseAligned = {queueBase[ADDR_W-1:2], 2'b00};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fmtRx  <= 1'b0;
      fmtA64 <= 1'b0;
      fmtExt <= 1'b0;
    end else if (stb.latchFmt) begin
      fmtRx  <= rxMode;
      fmtA64 <= cfgWord[CFG_A64];
      fmtExt <= rxMode ? cfgWord[CFG_EXT_RX] : cfgWord[CFG_EXT_TX];
    end
  end

  assign wordCnt  = IDX_W'(2) + (fmtA64 ? IDX_W'(2) : '0) + (fmtExt ? IDX_W'(2) : '0);
  assign extBase  = fmtA64 ? IDX_W'(4) : IDX_W'(2);
  assign lastWord = (wordIdx == wordCnt - IDX_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              wordIdx <= '0;
    else if (stb.firstWord) wordIdx <= '0;
    else if (stb.nextWord)  wordIdx <= wordIdx + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ptr <= '0;
    else if (stb.loadBase) ptr <= baseAligned;
    else if (stb.stepRing) ptr <= bufWrap ? baseAligned : ptr + (ADDR_W'(wordCnt) << 2);
  end

  assign curDesc = ptr;
  assign memAddr = ptr + (ADDR_W'(wordIdx) << 2);

  for (genvar g = 0; g < MAX_WORDS; g++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       words[g] <= '0;
      else if (stb.capWord && wordIdx == IDX_W'(g))    words[g] <= rdData;
    end
  end

  assign lo       = fmtRx ? {words[0][WORD_W-1:2], 2'b00} : words[0];
  assign hi       = fmtA64 ? words[2] : '0;
  assign bufAddr  = {hi, lo};
  assign bufWrap  = fmtRx ? words[0][RX_WRAP] : words[1][TX_WRAP];
  assign bufLen   = fmtRx ? LEN_W'(words[1][RX_LEN_W-1:0]) : words[1][LEN_W-1:0];
  assign stopHere = fmtRx ? words[0][RX_OWN] : words[1][TX_USED];
  assign invalid  = !fmtRx && (bufAddr == '0 || bufLen == '0);

  always_comb begin
    wrData = '0;
    for (int k = 0; k < MAX_WORDS; k++)
      if (wordIdx == IDX_W'(k)) wrData = words[k];
    if (wordIdx == IDX_W'(0) && fmtRx)
      wrData = words[0] | WORD_W'(1 << RX_OWN);
    if (wordIdx == IDX_W'(1))
      wrData = fmtRx ? statusIn : {1'b1, bufWrap, statusIn[WORD_W-3:0]};
    if (fmtExt && wordIdx >= extBase)
      wrData = '0;
  end

  AST_DESC_ALIGNED: assert property (@(posedge clk) disable iff (!rstN) curDesc[1:0] == 2'b00); // R9
  AST_WORD_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    (wordCnt <= IDX_W'(MAX_WORDS)) && !wordCnt[0] && (wordCnt >= IDX_W'(2))); // R1
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN) wordIdx < wordCnt); // R2
  AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    stb.capWord && !lastWord |=> $stable(wordCnt)); // R10
endmodule

// File: rtl/walkCtrl.sv
module walkCtrl
  import walkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        kick,
  input  logic        rewind,
  input  logic        rdReady,
  input  logic        rdValid,
  input  logic        wrReady,
  input  logic        done,
  input  logic        lastWord,
  input  logic        stopHere,
  input  logic        invalid,
  output walkStrobe_t stb,
  output logic        rdReq,
  output logic        wrReq,
  output logic        descValid,
  output logic        idle,
  output logic        halted
);
  typedef enum logic [2:0] {S_IDLE, S_RDREQ, S_RDWAIT, S_CHECK, S_OFFER, S_WRREQ, S_HALT} walkState_t;
  walkState_t st, nxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= S_IDLE;
    else       st <= nxt;
  end

  always_comb begin
    stb       = '0;
    nxt       = st;
    rdReq     = 1'b0;
    wrReq     = 1'b0;
    descValid = 1'b0;
    case (st)
      S_IDLE, S_HALT: begin
        if (kick) begin
          stb.latchFmt  = 1'b1;
          stb.firstWord = 1'b1;
          nxt           = S_RDREQ;
        end else if (rewind) begin
          stb.loadBase = 1'b1;
        end
      end
      S_RDREQ: begin
        rdReq = 1'b1;
        if (rdReady) nxt = S_RDWAIT;
      end
      S_RDWAIT: begin
        if (rdValid) begin
          stb.capWord = 1'b1;
          if (lastWord) nxt = S_CHECK;
          else begin
            stb.nextWord = 1'b1;
            nxt          = S_RDREQ;
          end
        end
      end
      S_CHECK: begin
        if (stopHere)     nxt = S_IDLE;
        else if (invalid) nxt = S_HALT;
        else              nxt = S_OFFER;
      end
      S_OFFER: begin
        descValid = 1'b1;
        if (done) begin
          stb.firstWord = 1'b1;
          nxt           = S_WRREQ;
        end
      end
      S_WRREQ: begin
        wrReq = 1'b1;
        if (wrReady) begin
          if (lastWord) begin
            stb.stepRing  = 1'b1;
            stb.latchFmt  = 1'b1;
            stb.firstWord = 1'b1;
            nxt           = S_RDREQ;
          end else begin
            stb.nextWord = 1'b1;
          end
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign idle   = (st == S_IDLE);
  assign halted = (st == S_HALT);

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) !(rdReq && wrReq)); // R2
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN) rdReq && !rdReady |=> rdReq); // R2
  AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rstN) descValid && !done |=> descValid); // R3
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN) halted |-> !wrReq && !descValid); // R6
endmodule

// File: rtl/ringWalker.sv
module ringWalker
  import walkPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxMode,
  input  logic [31:0] cfgWord,
  input  logic [31:0] queueBase,
  input  logic        rewind,
  input  logic        kick,
  output logic        rdReq,
  output logic [31:0] rdAddr,
  input  logic        rdReady,
  input  logic        rdValid,
  input  logic [31:0] rdData,
  output logic        wrReq,
  output logic [31:0] wrAddr,
  output logic [31:0] wrData,
  input  logic        wrReady,
  output logic        descValid,
  output logic [63:0] bufAddr,
  output logic [13:0] bufLen,
  output logic        bufWrap,
  input  logic        done,
  input  logic [31:0] statusIn,
  output logic [31:0] curDesc,
  output logic        idle,
  output logic        halted
);
  walkStrobe_t stb;
  logic        lastWord, stopHere, invalid;
  logic [31:0] memAddr;

  walkCtrl i_walkCtrl (
    .clk(clk), .rstN(rstN), .kick(kick), .rewind(rewind),
    .rdReady(rdReady), .rdValid(rdValid), .wrReady(wrReady), .done(done),
    .lastWord(lastWord), .stopHere(stopHere), .invalid(invalid),
    .stb(stb), .rdReq(rdReq), .wrReq(wrReq), .descValid(descValid),
    .idle(idle), .halted(halted)
  );

  walkData #(.ADDR_W(32)) i_walkData (
    .clk(clk), .rstN(rstN), .stb(stb), .rxMode(rxMode), .cfgWord(cfgWord),
    .queueBase(queueBase), .rdData(rdData), .statusIn(statusIn),
    .memAddr(memAddr), .curDesc(curDesc), .wrData(wrData),
    .lastWord(lastWord), .stopHere(stopHere), .invalid(invalid),
    .bufAddr(bufAddr), .bufLen(bufLen), .bufWrap(bufWrap)
  );

  assign rdAddr = memAddr;
  assign wrAddr = memAddr;

  AST_RD_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdReady |=> $stable(rdAddr)); // R2
  AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    descValid && !done |=> $stable(bufAddr) && $stable(bufLen) && $stable(bufWrap)); // R3
  AST_WR_WITHIN_DESC: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> (wrAddr >= curDesc) && (wrAddr < curDesc + 32'd24)); // R8
endmodule

// File: tb/test_ringWalker.sv
`timescale 1ns/1ps
module test_ringWalker;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxMode = 1'b0;
  logic [31:0] cfgWord = '0;
  logic [31:0] queueBase = 32'h43;
  logic rewind = 1'b0, kick = 1'b0, done = 1'b0;
  logic [31:0] statusIn = '0;
  logic rdReq, wrReq, descValid, bufWrap, idle, halted;
  logic [31:0] rdAddr, wrAddr, wrData, curDesc;
  logic [63:0] bufAddr;
  logic [13:0] bufLen;
  logic rdReady = 1'b0, rdValid = 1'b0, wrReady = 1'b0;
  logic [31:0] rdData = '0;
  logic [31:0] mem [64];
  logic [31:0] orig [64];
  int errors = 0, checks = 0, cyc = 0;

  always #10 clk = ~clk;

  ringWalker i_ringWalker (
    .clk(clk), .rstN(rstN), .rxMode(rxMode), .cfgWord(cfgWord), .queueBase(queueBase),
    .rewind(rewind), .kick(kick), .rdReq(rdReq), .rdAddr(rdAddr), .rdReady(rdReady),
    .rdValid(rdValid), .rdData(rdData), .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData),
    .wrReady(wrReady), .descValid(descValid), .bufAddr(bufAddr), .bufLen(bufLen),
    .bufWrap(bufWrap), .done(done), .statusIn(statusIn), .curDesc(curDesc),
    .idle(idle), .halted(halted)
  );

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rdReady <= (cyc % 3) != 1;
    wrReady <= (cyc % 5) != 2;
    rdValid <= 1'b0;
    if (rdReq && rdReady) begin
      rdValid <= 1'b1;
      rdData  <= mem[rdAddr[7:2]];
    end
    if (wrReq && wrReady) mem[wrAddr[7:2]] <= wrData;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  task automatic pulse(input bit isKick);
    @(negedge clk);
    if (isKick) kick = 1'b1; else rewind = 1'b1;
    @(negedge clk);
    kick = 1'b0; rewind = 1'b0;
  endtask

  // waits for an offer or a stop; got=1 when an offer appeared
  task automatic waitEvent(output bit got);
    got = 1'b0;
    for (int t = 0; t < 3000; t++) begin
      @(negedge clk);
      if (descValid) begin got = 1'b1; return; end
      if (idle || halted) return;
    end
    check(1'b0, "R2", "wait timeout", 0, 1);
  endtask

  task automatic giveDone(input logic [31:0] st);
    statusIn = st;
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) begin mem[i] = 32'hC0DE_0000 | i; orig[i] = mem[i]; end
  endtask

  task automatic put(input int a, input logic [31:0] v);
    mem[a >> 2] = v; orig[a >> 2] = v;
  endtask

  // three-descriptor ring; the last wraps back to base
  task automatic runRing(input bit rx, input bit a64, input bit ext);
    int n, base, da;
    bit got;
    logic [31:0] w0, w1, st, hiW, expW;
    logic [63:0] expAddr;
    logic [13:0] expLen;
    string req;
    n = 2 + (a64 ? 2 : 0) + (ext ? 2 : 0);
    base = 32'h40;
    rxMode = rx;
    cfgWord = (32'(a64) << 30) | (rx ? ((32'(ext) << 28) | (32'(!ext) << 29))
                                     : ((32'(ext) << 29) | (32'(!ext) << 28)));
    clearMem();
    for (int d = 0; d < 3; d++) begin
      da = base + 4 * n * d;
      if (rx) begin
        w0 = 32'h1000_0000 + 32'h100 * (d + 1) + ((d == 2) ? 32'h2 : 32'h0);
        w1 = 32'hABCD_E000 | (32'h1000 + d + 3);
      end else begin
        w0 = 32'h2000_0000 + 32'h100 * (d + 1) + d;
        w1 = ((d == 2) ? 32'h4000_0000 : 32'h0) | 32'h2000 | (d * 7 + 3);
      end
      put(da, w0); put(da + 4, w1);
      if (n > 2) put(da + 8, 32'hA0 + d);
      if (n > 3) put(da + 12, 32'h5A5A_0000 + d);
      if (n > 4) begin put(da + 16, 32'hFFFF_FFFF); put(da + 20, 32'h8000_0001); end
    end
    pulse(1'b0);
    check(curDesc == 32'h40, "R9", "rewind masks base", curDesc, 32'h40);
    pulse(1'b1);
    for (int d = 0; d < 3; d++) begin
      da = base + 4 * n * d;
      waitEvent(got);
      check(got, rx ? "R4" : "R5", "offer present", got, 1);
      if (!got) return;
      w0 = orig[da >> 2]; w1 = orig[(da >> 2) + 1];
      hiW = a64 ? orig[(da >> 2) + 2] : 32'h0;
      expAddr = {hiW, rx ? (w0 & 32'hFFFF_FFFC) : w0};
      expLen = rx ? 14'(w1[12:0]) : w1[13:0];
      check(curDesc == 32'(da), "R7", "descriptor stride", curDesc, da);
      check(bufAddr == expAddr, "R3", "buffer address", bufAddr, expAddr);
      check(bufLen == expLen, rx ? "R4" : "R5", "length field", bufLen, expLen);
      check(bufWrap == (d == 2), rx ? "R4" : "R5", "wrap flag", bufWrap, (d == 2));
      giveDone(32'hF000_0040 + d);
    end
    waitEvent(got);
    check(!got && idle, rx ? "R4" : "R5", "stops on written-back base", {got, idle}, 2'b01);
    check(curDesc == 32'h40, "R7", "wrap returns to base", curDesc, 32'h40);
    for (int d = 0; d < 3; d++) begin
      da = base + 4 * n * d;
      st = 32'hF000_0040 + d;
      for (int i = 0; i < n; i++) begin
        w0 = orig[(da >> 2) + i];
        if (i == 0) expW = rx ? (w0 | 32'h1) : w0;
        else if (i == 1) expW = rx ? st : {1'b1, (d == 2), st[29:0]};
        else if (ext && i >= (a64 ? 4 : 2)) expW = 32'h0;
        else expW = w0;
        req = (i >= 2) ? ((ext && i >= (a64 ? 4 : 2)) ? "R8" : "R1") : "R8";
        check(mem[(da >> 2) + i] == expW, req, $sformatf("writeback d%0d w%0d", d, i),
              mem[(da >> 2) + i], expW);
      end
    end
    check(mem[(base + 12 * n) >> 2] == orig[(base + 12 * n) >> 2], "R8", "no write past ring",
          mem[(base + 12 * n) >> 2], orig[(base + 12 * n) >> 2]);
  endtask

  initial begin
    bit got;
    clearMem();
    repeat (3) @(negedge clk);
    check(idle && !halted && !rdReq && !wrReq && !descValid, "R11", "reset outputs",
          {idle, halted, rdReq, wrReq, descValid}, 5'b10000);
    check(curDesc == 32'h0, "R11", "reset pointer", curDesc, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 R3 R4 R5 R7 R8 R9: every format in both directions
    for (int m = 0; m < 8; m++) runRing(m[2], m[1], m[0]);

    // R6: zero length transmit descriptor
    rxMode = 1'b0; cfgWord = 32'h0; clearMem();
    put(32'h40, 32'h3000_0000); put(32'h44, 32'h4000_0000);
    pulse(1'b0); pulse(1'b1);
    waitEvent(got);
    check(!got && halted, "R6", "zero length halts", {got, halted}, 2'b01);
    check(mem[17] == orig[17], "R6", "no writeback on invalid", mem[17], orig[17]);
    // R6: zero address transmit descriptor
    put(32'h40, 32'h0); put(32'h44, 32'h4000_0009);
    pulse(1'b0); pulse(1'b1);
    waitEvent(got);
    check(!got && halted, "R6", "zero address halts", {got, halted}, 2'b01);
    check(curDesc == 32'h40, "R6", "pointer unchanged", curDesc, 32'h40);
    // R3 R6: low word zero but high word set is a valid address
    cfgWord = 32'h4000_0000;
    put(32'h40, 32'h0); put(32'h44, 32'h4000_0004); put(32'h48, 32'h1);
    pulse(1'b0); pulse(1'b1);
    waitEvent(got);
    check(got, "R6", "nonzero high word accepted", got, 1);
    check(bufAddr == 64'h1_0000_0000, "R3", "high word only", bufAddr, 64'h1_0000_0000);
    giveDone(32'h0);
    waitEvent(got);
    check(idle && !got, "R5", "stops after wrap", {got, idle}, 2'b01);

    // R10: format change during an offer applies to the next descriptor
    rxMode = 1'b0; cfgWord = 32'h0; clearMem();
    put(32'h40, 32'h2000_0010); put(32'h44, 32'h5);
    put(32'h48, 32'h2000_0020); put(32'h4C, 32'h4000_0006);
    put(32'h50, 32'h77); put(32'h54, 32'h11);
    pulse(1'b0); pulse(1'b1);
    waitEvent(got);
    check(got && curDesc == 32'h40, "R10", "first offer", curDesc, 32'h40);
    cfgWord = 32'h4000_0000;
    @(negedge clk);
    check(bufAddr == 64'h2000_0010, "R10", "offer keeps old format", bufAddr, 64'h2000_0010);
    giveDone(32'h0000_0123);
    waitEvent(got);
    check(got && curDesc == 32'h48, "R10", "old stride used", curDesc, 32'h48);
    check(mem[18] == orig[18], "R10", "writeback length kept", mem[18], orig[18]);
    check(bufAddr == {32'h77, 32'h2000_0020}, "R10", "new format on next", bufAddr,
          {32'h77, 32'h2000_0020});
    giveDone(32'h0000_0456);
    waitEvent(got);
    check(idle && !got && curDesc == 32'h40, "R7", "wrap to base", curDesc, 32'h40);
    check(mem[17] == 32'h8000_0123, "R8", "tx status word", mem[17], 32'h8000_0123);
    check(mem[19] == 32'hC000_0456, "R8", "tx status with wrap", mem[19], 32'hC000_0456);
    check(mem[20] == 32'h77, "R8", "high word kept", mem[20], 32'h77);
    finishRun();
  end
endmodule